// File: doc/BRIEF.md
# A/D Conversion Trigger and Scan Controller

This block decides when an external analog-to-digital converter begins a conversion and which input channel that conversion uses. A conversion can be requested in three ways: a software strobe, the falling edge of an internal timer output, or the falling edge of an external trigger pin. An optional level gate decides whether hardware triggers are accepted and can pause a scan that is already running. Channels are stepped between a programmable low and high channel number. After the high channel the sequence wraps back to the low channel.

A settling hold-off blocks new starts for a fixed time after any change of channel or of the analog configuration. In scan mode, one trigger converts every channel from the current one up to the high channel. Consecutive conversions in a scan are spaced by one of four intervals. The status output stays high for the whole scan. The block drives a one-cycle start pulse and the channel number. The converter reports back with a busy level and a one-cycle done pulse.

The control is a four-state machine:
- **IDLE**: waits for an accepted trigger, then goes to **FIRE**.
- **FIRE**: lasts one cycle, drives the start pulse, then goes to **CONV**.
- **CONV**: waits for the converter's done pulse and advances the channel. On done it goes to **GAP** when a scan still has channels left, and to **IDLE** otherwise.
- **GAP**: waits until the interval has expired, the settling hold-off is clear and the gate is open, then goes to **FIRE**.

Top module: `adc_trig_scan`

## Requirements
- R1: In IDLE, with the hardware clock disabled, no settling and the gate open, a one-cycle `sw_start` strobe makes `conv_start` rise after the following clock edge.
- R2: A `sw_start` strobe that arrives while a conversion or scan is in progress (state not IDLE) starts nothing.
- R3: While `hw_clk_en` is 1, `sw_start` has no effect.
- R4: With `hw_clk_en` = 1, a falling edge is detected after a two-flop synchroniser. `clk_sel` = 1 makes falling edges of `int_tick` start conversions. `clk_sel` = 0 makes falling edges of `ext_trig` start conversions. The source that is not selected is ignored.
- R5: `lo_wr` loads the 5-bit low channel and also loads the current channel, visible on `chan` after that edge. `hi_wr` loads the 5-bit high channel. Both reset to 0. `chan` always shows the channel the next conversion will use.
- R6: When a conversion completes (`conv_done` in CONV), the current channel advances by one. If it was equal to the high channel, it returns to the low channel instead.
- R7: With `gate_en` = 1, starts are accepted only while the synchronised `gate_pin` is high. A trigger that arrives while the gate is low is dropped. A scan that is waiting for its next conversion pauses while the gate is low and resumes when the gate returns high.
- R8: With `scan_en` = 1, `status` is high from the start pulse until the conversion of the high channel completes. The scan then ends in IDLE. With `scan_en` = 0, `status` equals `conv_busy`.
- R9: Within a scan, the next start needs the interval counter to expire. The counter is loaded on done with 4, 5, 10 or 15 µs for `scan_code` 0, 1, 2 or 3, times `CLK_MHZ` cycles. FIRE follows on the edge after the counter reaches 0.
- R10: A low-channel write, a `cfg_change` pulse, or a channel advance that changes the channel each load the settling counter with `SETTLE_US`×`CLK_MHZ` cycles. `settling` is high while that counter is nonzero. No start is accepted while it is high, and triggers arriving then are dropped.
- R11: `conv_start` is exactly one cycle wide. A hardware trigger arriving outside IDLE is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_start | input | 1 | Software start strobe |
| hw_clk_en | input | 1 | Hardware trigger enable; disables software starts |
| clk_sel | input | 1 | 1: internal timer edges, 0: external pin edges |
| gate_en | input | 1 | Enables the level gate |
| scan_en | input | 1 | Scan mode enable |
| scan_code | input | 2 | Scan interval code |
| int_tick | input | 1 | Internal timer output (falling edge triggers) |
| ext_trig | input | 1 | External trigger pin (falling edge triggers) |
| gate_pin | input | 1 | Gate level input |
| lo_wr | input | 1 | Low channel write strobe |
| lo_data | input | 5 | Low channel value |
| hi_wr | input | 1 | High channel write strobe |
| hi_data | input | 5 | High channel value |
| cfg_change | input | 1 | Pulse on a gain or range change |
| conv_busy | input | 1 | Converter busy level |
| conv_done | input | 1 | Converter completion pulse |
| conv_start | output | 1 | One-cycle conversion start |
| chan | output | 5 | Current channel, used by the next conversion |
| status | output | 1 | Conversion or scan in progress |
| settling | output | 1 | Settling hold-off active |

## Verification
The bench builds the block with `CLK_MHZ` = 2 and `SETTLE_US` = 10. That gives a 20-cycle settling window and scan intervals of 8, 10, 20 and 30 cycles. With these values, both orders of the two waits are reachable within a few hundred cycles. With code 3 the interval is longer and dominates the spacing between starts. With code 0 the settling window is longer and dominates instead. The same short settling window also lets a trigger land inside the hold-off, so the dropped-trigger case is covered. A gate pause is held in the middle of a scan and then released.

// File: rtl/adts_pkg.sv
package adts_pkg;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_FIRE = 2'd1,
        S_CONV = 2'd2,
        S_GAP  = 2'd3
    } adts_state_e;

    // Longest scan interval in microseconds (code 3)
    localparam int unsigned GAP_US_MAX = 15;

    // Scan interval in microseconds for each 2-bit code
    function automatic int unsigned scan_gap_us(input logic [1:0] code);
        int unsigned us;
        unique case (code)
            2'd0: us = 4;
            2'd1: us = 5;
            2'd2: us = 10;
            default: us = GAP_US_MAX;
        endcase
        return us;
    endfunction

endpackage

// File: rtl/adts_sync.sv
module adts_sync #(
    parameter int N    = 2,
    parameter bit EDGE = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] din,
    output logic [N-1:0] q
);

    genvar i;
    generate
        for (i = 0; i < N; i++) begin : g_bit
            if (EDGE) begin : g_edge
                logic [2:0] sh;
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sh <= '0;
                    else        sh <= {sh[1:0], din[i]};
                end
                assign q[i] = sh[2] & ~sh[1];

                // R4: a detected falling edge lasts exactly one cycle
                a_r4_edge_single: assert property (@(posedge clk) disable iff (!rst_n)
                    q[i] |=> !q[i]);
            end else begin : g_level
                logic [1:0] sh;
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sh <= '0;
                    else        sh <= {sh[0], din[i]};
                end
                assign q[i] = sh[1];
            end
        end
    endgenerate

endmodule

// File: rtl/adts_countdown.sv
module adts_countdown #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         busy
);

    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           cnt <= '0;
        else if (load)        cnt <= load_val;
        else if (cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);

    // R10/R9: an unloaded counter only ever steps down by one
    a_r10_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && busy) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/adts_chan_seq.sv
module adts_chan_seq #(
    parameter int CH_W = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            lo_wr,
    input  logic [CH_W-1:0] lo_data,
    input  logic            hi_wr,
    input  logic [CH_W-1:0] hi_data,
    input  logic            adv,
    output logic [CH_W-1:0] cur,
    output logic            at_hi,
    output logic            moved
);

    logic [CH_W-1:0] lo_q;
    logic [CH_W-1:0] hi_q;
    logic [CH_W-1:0] nxt;

    always_comb begin
        at_hi = (cur == hi_q);
        nxt   = at_hi ? lo_q : CH_W'(cur + 1'b1);
        moved = lo_wr || (adv && (nxt != cur));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
            cur  <= '0;
        end else begin
            if (lo_wr) lo_q <= lo_data;
            if (hi_wr) hi_q <= hi_data;
            if (lo_wr)    cur <= lo_data;
            else if (adv) cur <= nxt;
        end
    end

    // R5: a low-channel write lands in the current channel
    a_r5_lo_load: assert property (@(posedge clk) disable iff (!rst_n)
        lo_wr |=> (cur == $past(lo_data)));

    // R6: advancing from the high channel returns to the low channel
    a_r6_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !lo_wr && (cur == hi_q)) |=> (cur == $past(lo_q)));

endmodule

// File: rtl/adc_trig_scan.sv
module adc_trig_scan #(
    parameter int CLK_MHZ   = 100,
    parameter int SETTLE_US = 10,
    parameter int CH_W      = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sw_start,
    input  logic            hw_clk_en,
    input  logic            clk_sel,
    input  logic            gate_en,
    input  logic            scan_en,
    input  logic [1:0]      scan_code,
    input  logic            int_tick,
    input  logic            ext_trig,
    input  logic            gate_pin,
    input  logic            lo_wr,
    input  logic [CH_W-1:0] lo_data,
    input  logic            hi_wr,
    input  logic [CH_W-1:0] hi_data,
    input  logic            cfg_change,
    input  logic            conv_busy,
    input  logic            conv_done,
    output logic            conv_start,
    output logic [CH_W-1:0] chan,
    output logic            status,
    output logic            settling
);
    import adts_pkg::*;

    localparam int unsigned MAX_US  = (SETTLE_US > GAP_US_MAX) ? SETTLE_US : GAP_US_MAX;
    localparam int unsigned MAX_CYC = MAX_US * CLK_MHZ;
    localparam int          CNT_W   = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] SETTLE_CYC = CNT_W'(SETTLE_US * CLK_MHZ);

    adts_state_e state_q, state_d;

    logic [1:0]       trig_fall;
    logic [0:0]       gate_lvl;
    logic             hw_trig;
    logic             gate_ok;
    logic             sw_ok;
    logic             accept;
    logic             adv;
    logic             at_hi;
    logic             moved;
    logic             gap_busy;
    logic [CNT_W-1:0] gap_val;

    // Trigger edge detection: bit 0 internal timer, bit 1 external pin
    adts_sync #(.N(2), .EDGE(1'b1)) u_trig_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({ext_trig, int_tick}),
        .q     (trig_fall)
    );

    adts_sync #(.N(1), .EDGE(1'b0)) u_gate_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (gate_pin),
        .q     (gate_lvl)
    );

    adts_chan_seq #(.CH_W(CH_W)) u_chan (
        .clk     (clk),
        .rst_n   (rst_n),
        .lo_wr   (lo_wr),
        .lo_data (lo_data),
        .hi_wr   (hi_wr),
        .hi_data (hi_data),
        .adv     (adv),
        .cur     (chan),
        .at_hi   (at_hi),
        .moved   (moved)
    );

    adts_countdown #(.W(CNT_W)) u_settle (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (moved || cfg_change),
        .load_val (SETTLE_CYC),
        .busy     (settling)
    );

    adts_countdown #(.W(CNT_W)) u_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (adv),
        .load_val (gap_val),
        .busy     (gap_busy)
    );

    always_comb begin
        hw_trig = hw_clk_en && (clk_sel ? trig_fall[0] : trig_fall[1]);
        gate_ok = !gate_en || gate_lvl[0];
        sw_ok   = sw_start && !hw_clk_en;
        accept  = !settling && gate_ok && (sw_ok || hw_trig);
        adv     = (state_q == S_CONV) && conv_done;
        gap_val = CNT_W'(scan_gap_us(scan_code) * CLK_MHZ);
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (accept) state_d = S_FIRE;
            S_FIRE: state_d = S_CONV;
            S_CONV: if (conv_done) state_d = (scan_en && !at_hi) ? S_GAP : S_IDLE;
            S_GAP:  if (!gap_busy && !settling && gate_ok) state_d = S_FIRE;
        endcase
    end

    // Outputs
    always_comb begin
        conv_start = (state_q == S_FIRE);
        status     = scan_en ? (state_q != S_IDLE) : conv_busy;
    end

    // R11: start pulse is one cycle wide
    a_r11_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);

    // R10: an idle controller that is settling does not fire
    a_r10_hold_settling: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == S_IDLE) && settling) |=> !conv_start);

    // R2: no new start while the converter has not finished
    a_r2_conv_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == S_CONV) && !conv_done) |=> !conv_start);

    // R3: with hardware clocking only a hardware edge can fire
    a_r3_sw_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == S_IDLE) && hw_clk_en && !hw_trig) |=> !conv_start);

    // R8: a scan start raises status
    a_r8_scan_status: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_en && conv_start) |-> status);

endmodule

// File: tb/sim_adc_trig_scan.sv
module sim_adc_trig_scan;

    localparam int CLK_MHZ   = 2;
    localparam int SETTLE_US = 10;
    localparam int SET_CYC   = SETTLE_US * CLK_MHZ;
    localparam int CONV_T    = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sw_start = 1'b0, hw_clk_en = 1'b0, clk_sel = 1'b0;
    logic       gate_en = 1'b0, scan_en = 1'b0;
    logic [1:0] scan_code = 2'd0;
    logic       int_tick = 1'b0, ext_trig = 1'b1, gate_pin = 1'b1;
    logic       lo_wr = 1'b0, hi_wr = 1'b0, cfg_change = 1'b0;
    logic [4:0] lo_data = '0, hi_data = '0;
    logic       conv_busy = 1'b0, conv_done = 1'b0;
    logic       conv_start, status, settling;
    logic [4:0] chan;

    always #4 clk = ~clk;

    adc_trig_scan #(.CLK_MHZ(CLK_MHZ), .SETTLE_US(SETTLE_US), .CH_W(5)) u0 (
        .clk(clk), .rst_n(rst_n), .sw_start(sw_start), .hw_clk_en(hw_clk_en),
        .clk_sel(clk_sel), .gate_en(gate_en), .scan_en(scan_en), .scan_code(scan_code),
        .int_tick(int_tick), .ext_trig(ext_trig), .gate_pin(gate_pin),
        .lo_wr(lo_wr), .lo_data(lo_data), .hi_wr(hi_wr), .hi_data(hi_data),
        .cfg_change(cfg_change), .conv_busy(conv_busy), .conv_done(conv_done),
        .conv_start(conv_start), .chan(chan), .status(status), .settling(settling)
    );

    int checks = 0, fails = 0, cyc_n = 0, starts = 0;
    int last_start = 0, prev_start = 0, bcnt = 0;
    bit finished = 0;

    // Converter model: busy for CONV_T cycles, then a done pulse
    always @(negedge clk) begin
        conv_done = 1'b0;
        if (bcnt > 0) begin
            bcnt--;
            if (bcnt == 0) begin
                conv_busy = 1'b0;
                conv_done = 1'b1;
            end
        end
        if (conv_start) begin
            conv_busy = 1'b1;
            bcnt = CONV_T;
        end
    end

    // Behavioural reference model
    int m_state, m_lo, m_hi, m_cur, m_settle, m_gap;
    bit [2:0] hi_i, hi_e;
    bit [1:0] hi_g;

    function automatic int gap_cycles(input logic [1:0] c);
        case (c)
            2'd0: return 4 * CLK_MHZ;
            2'd1: return 5 * CLK_MHZ;
            2'd2: return 10 * CLK_MHZ;
            default: return 15 * CLK_MHZ;
        endcase
    endfunction

    always @(posedge clk) begin
        bit fi, fe, hw, gok, adv;
        int nxt, ns;
        if (!rst_n) begin
            m_state = 0; m_lo = 0; m_hi = 0; m_cur = 0; m_settle = 0; m_gap = 0;
            hi_i = '0; hi_e = '0; hi_g = '0;
        end else begin
            fi  = hi_i[2] && !hi_i[1];
            fe  = hi_e[2] && !hi_e[1];
            hw  = hw_clk_en && (clk_sel ? fi : fe);
            gok = !gate_en || hi_g[1];
            adv = (m_state == 2) && conv_done;
            nxt = (m_cur == m_hi) ? m_lo : (m_cur + 1) % 32;
            ns  = m_state;
            case (m_state)
                0: if (m_settle == 0 && gok && ((sw_start && !hw_clk_en) || hw)) ns = 1;
                1: ns = 2;
                2: if (conv_done) ns = (scan_en && m_cur != m_hi) ? 3 : 0;
                default: if (m_gap == 0 && m_settle == 0 && gok) ns = 1;
            endcase
            if (lo_wr || cfg_change || (adv && nxt != m_cur)) m_settle = SET_CYC;
            else if (m_settle > 0) m_settle--;
            if (adv) m_gap = gap_cycles(scan_code);
            else if (m_gap > 0) m_gap--;
            if (lo_wr) m_cur = lo_data;
            else if (adv) m_cur = nxt;
            if (lo_wr) m_lo = lo_data;
            if (hi_wr) m_hi = hi_data;
            m_state = ns;
            hi_i = {hi_i[1:0], int_tick};
            hi_e = {hi_e[1:0], ext_trig};
            hi_g = {hi_g[0], gate_pin};
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // Per-cycle comparison against the model, away from the edge
    always @(posedge clk) begin
        #2;
        if (rst_n && !finished) begin
            cyc_n++;
            chk("R11 start pulse", int'(conv_start), int'(m_state == 1));
            chk("R6 channel", int'(chan), m_cur);
            chk("R10 settling", int'(settling), int'(m_settle != 0));
            chk("R8 status", int'(status), scan_en ? int'(m_state != 0) : int'(conv_busy));
            if (conv_start) begin
                starts++;
                prev_start = last_start;
                last_start = cyc_n;
            end
            if (cyc_n > 20000) begin
                finished = 1;
                fails++;
                $display("FAIL watchdog (all requirements): actual %0d cycles expected completion", cyc_n);
                summary();
            end
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_lo(input int v);
        lo_data = 5'(v); lo_wr = 1'b1; cyc(1); lo_wr = 1'b0;
    endtask

    task automatic wr_hi(input int v);
        hi_data = 5'(v); hi_wr = 1'b1; cyc(1); hi_wr = 1'b0;
    endtask

    task automatic sw_pulse();
        sw_start = 1'b1; cyc(1); sw_start = 1'b0;
    endtask

    task automatic ext_pulse();
        ext_trig = 1'b0; cyc(2); ext_trig = 1'b1;
    endtask

    task automatic tick_pulse();
        int_tick = 1'b1; cyc(2); int_tick = 1'b0;
    endtask

    initial begin
        int c;
        cyc(4);
        rst_n = 1'b1;
        cyc(1);
        chk("R5 reset chan", int'(chan), 0);
        chk("R8 reset status", int'(status), 0);
        chk("R10 reset settling", int'(settling), 0);
        chk("R11 reset start", int'(conv_start), 0);

        wr_hi(5); wr_lo(3);
        chk("R5 lo write loads chan", int'(chan), 3);
        chk("R10 lo write settles", int'(settling), 1);
        cyc(30);

        c = starts; sw_pulse(); cyc(3);
        chk("R1 software start", starts - c, 1);
        cyc(10);
        chk("R6 advance", int'(chan), 4);
        cyc(30);

        c = starts; sw_pulse(); cyc(3); sw_pulse(); cyc(40);
        chk("R2 strobe while busy ignored", starts - c, 1);

        hw_clk_en = 1'b1;
        c = starts; sw_pulse(); cyc(40);
        chk("R3 software blocked", starts - c, 0);

        clk_sel = 1'b1;
        c = starts; tick_pulse(); cyc(40);
        chk("R4 internal edge", starts - c, 1);
        chk("R6 wrap to low", int'(chan), 3);
        c = starts; ext_pulse(); cyc(40);
        chk("R4 unselected pin ignored", starts - c, 0);
        clk_sel = 1'b0;
        c = starts; ext_pulse(); cyc(40);
        chk("R4 external edge", starts - c, 1);

        gate_en = 1'b1; gate_pin = 1'b0; cyc(4);
        c = starts; ext_pulse(); cyc(40);
        chk("R7 gated trigger", starts - c, 0);
        gate_pin = 1'b1; cyc(40);
        chk("R7 dropped trigger not replayed", starts - c, 0);
        ext_pulse(); cyc(40);
        chk("R7 open gate", starts - c, 1);

        wr_hi(4); wr_lo(1); scan_code = 2'd3; scan_en = 1'b1; cyc(30);
        c = starts; ext_pulse(); cyc(6);
        chk("R8 scan status high", int'(status), 1);
        cyc(200);
        chk("R8 scan converts range", starts - c, 4);
        chk("R9 interval spacing", last_start - prev_start, CONV_T + 2 + gap_cycles(2'd3));
        chk("R6 scan wraps", int'(chan), 1);
        chk("R8 scan ends", int'(status), 0);

        scan_code = 2'd0;
        c = starts; ext_pulse(); cyc(20);
        gate_pin = 1'b0; cyc(60);
        chk("R7 scan paused", starts - c, 1);
        chk("R8 status held in pause", int'(status), 1);
        gate_pin = 1'b1; cyc(150);
        chk("R7 scan resumed", starts - c, 4);
        chk("R10 settle spacing", last_start - prev_start, CONV_T + 2 + SET_CYC);

        scan_en = 1'b0; cyc(40);
        cfg_change = 1'b1; cyc(1); cfg_change = 1'b0;
        chk("R10 config change settles", int'(settling), 1);
        c = starts; ext_pulse(); cyc(40);
        chk("R10 trigger dropped while settling", starts - c, 0);

        finished = 1;
        summary();
    end

endmodule